// File: doc/BRIEF.md
# Multiplexed address/data byte read sequencer

This block drives the pins of one asynchronous read from a byte-wide external memory that shares a 16-bit bus between address and data. A host presents a request with the address, a data-cycle count, a hold-cycle enable, a flash-recovery enable and the polarity of the address latch strobe. The sequencer first puts the whole address on both bus lanes and pulses the latch strobe. It then releases the low lane so the memory can return data there, while it keeps driving the upper address byte. It holds the read strobe low for the programmed number of cycles and captures the byte at the strobe's rising edge. A one-clock done pulse marks the capture. A busy flag then stays up through an optional hold and flash-recovery interval.

All timing is counted in peripheral ticks, and one tick is two core clocks. The tick divider restarts when a request is accepted, so every phase is a whole number of ticks long when measured from the acceptance edge.

Top module: `mux_rd_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `rd_n` and `wr_n` are 1, both lane enables are 0 and `ale` is 0, because the latch strobe is active high after reset.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. One tick is 2 clocks. The latch strobe is active for the 4 clocks after acceptance, and the full address is driven on `ad_out` with both enables at 1 during those clocks and for 2 clocks after them.
- R3: With `req_ale_low` at 1, `ale` is 0 while active and 1 otherwise. The accepted polarity stays on the idle pin until the next request.
- R4: The low-lane enable drops 2 clocks after the latch strobe ends, and `rd_n` falls 4 clocks after it ends.
- R5: `rd_n` stays low for 2·D clocks, where D is `req_dcyc` and a value of 0 counts as 1.
- R6: The byte on `ad_in` in the last clock of the low strobe appears on `rd_data` in the next clock, together with a one-clock `done` pulse. `rd_data` holds that byte afterwards.
- R7: The upper-lane enable stays at 1 with the upper address byte on `ad_out` through the strobe, and for 2 clocks after `rd_n` rises when `req_hold` is 1.
- R8: `busy` stays at 1 from the clock after acceptance until 2·(H+F) clocks after `rd_n` rises, where H is 1 if `req_hold` is set and F is 7 if `req_flash` is set (each 0 otherwise). A request made while busy is ignored.
- R9: `wr_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 16 | Read address |
| req_dcyc | input | 5 | Strobe length in ticks (0 means 1) |
| req_hold | input | 1 | Add one hold tick after the strobe |
| req_flash | input | 1 | Add seven recovery ticks after the strobe |
| req_ale_low | input | 1 | Latch strobe is active low |
| ad_in | input | 8 | Low bus lane input |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock capture pulse |
| rd_data | output | 8 | Captured byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, held inactive |
| ad_out | output | 16 | Bus output value |
| ad_oe_hi | output | 1 | Upper lane drive enable |
| ad_oe_lo | output | 1 | Low lane drive enable |

## Verification
The assertions assume that a request made while busy leaves the latched configuration unchanged. They also assume that the memory only needs `ad_in` to be valid during the low strobe. The stimulus makes requests only from the idle state, apart from one deliberate request made while busy. It drives a complementary byte on `ad_in` outside the strobe window, so a capture on the wrong edge shows up as the wrong byte. Every vector stays inside the 5-bit count field.

// File: rtl/mux_rd_seq_pkg.sv
package mux_rd_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LATCH  = 3'd1,
        PH_KEEP   = 3'd2,
        PH_TURN   = 3'd3,
        PH_STROBE = 3'd4,
        PH_RECOV  = 3'd5
    } phase_e;

endpackage

// File: rtl/mux_rd_seq_tick.sv
module mux_rd_seq_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        if (restart)           div_d = '0;
        else if (div_q == LAST) div_d = '0;
        else                   div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = (div_q == LAST) && !restart;

    // ticks never come on consecutive clocks when the divider is at least 2
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/mux_rd_seq_fsm.sv
module mux_rd_seq_fsm
    import mux_rd_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int DCYC_W      = 5,
    parameter int LATCH_TICKS = 2,
    parameter int FLASH_TICKS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DCYC_W-1:0] req_dcyc,
    input  logic              req_hold,
    input  logic              req_flash,
    input  logic              req_ale_low,
    input  logic [DATA_W-1:0] ad_in,
    output logic              accept,
    output phase_e            phase,
    output logic [DCYC_W:0]   cnt,
    output logic [DCYC_W:0]   flash_len,
    output logic [ADDR_W-1:0] addr,
    output logic              pol_low,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = DCYC_W + 1;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    dlen;
        logic                hold;
        logic                flash;
        logic                pol;
        logic [DATA_W-1:0]   data;
        logic                done;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] rlen;
    logic [CNT_W-1:0] flen;

    assign flen = s_q.flash ? CNT_W'(FLASH_TICKS) : '0;
    assign rlen = flen + CNT_W'(s_q.hold);
    assign accept = (s_q.ph == PH_IDLE) && req_valid;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.ph    = PH_LATCH;
            s_d.cnt   = CNT_W'(LATCH_TICKS - 1);
            s_d.addr  = req_addr;
            s_d.dlen  = (req_dcyc == '0) ? CNT_W'(1) : CNT_W'(req_dcyc);
            s_d.hold  = req_hold;
            s_d.flash = req_flash;
            s_d.pol   = req_ale_low;
        end else if (tick && s_q.ph != PH_IDLE) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                unique case (s_q.ph)
                    PH_LATCH: begin
                        s_d.ph  = PH_KEEP;
                        s_d.cnt = '0;
                    end
                    PH_KEEP: begin
                        s_d.ph  = PH_TURN;
                        s_d.cnt = '0;
                    end
                    PH_TURN: begin
                        s_d.ph  = PH_STROBE;
                        s_d.cnt = s_q.dlen - 1'b1;
                    end
                    PH_STROBE: begin
                        s_d.data = ad_in;
                        s_d.done = 1'b1;
                        if (rlen == '0) begin
                            s_d.ph = PH_IDLE;
                        end else begin
                            s_d.ph  = PH_RECOV;
                            s_d.cnt = rlen - 1'b1;
                        end
                    end
                    default: s_d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, dlen: CNT_W'(1), hold: 1'b0,
                     flash: 1'b0, pol: 1'b0, data: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.ph;
    assign cnt       = s_q.cnt;
    assign flash_len = flen;
    assign addr      = s_q.addr;
    assign pol_low   = s_q.pol;
    assign done      = s_q.done;
    assign rd_data   = s_q.data;

    // a request while a cycle runs must not disturb the latched address
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && req_valid) |=> $stable(s_q.addr));
    // done lasts exactly one clock
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    // the strobe phase always spans more than one clock
    assert_strobe_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_STROBE && $past(s_q.ph) != PH_STROBE) |=> s_q.ph == PH_STROBE);
    // done only follows the end of a strobe
    assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.ph) == PH_STROBE);
endmodule

// File: rtl/mux_rd_seq_pins.sv
module mux_rd_seq_pins
    import mux_rd_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DCYC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [DCYC_W:0]   cnt,
    input  logic [DCYC_W:0]   flash_len,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pol_low,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe_hi,
    output logic              ad_oe_lo
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic latch_on, lo_on, hi_on;

    always_comb begin
        latch_on = (phase == PH_LATCH);
        lo_on    = (phase == PH_LATCH) || (phase == PH_KEEP);
        hi_on    = lo_on || (phase == PH_TURN) || (phase == PH_STROBE) ||
                   ((phase == PH_RECOV) && (cnt >= flash_len));
    end

    assign ale      = latch_on ^ pol_low;
    assign rd_n     = (phase != PH_STROBE);
    assign wr_n     = 1'b1;
    assign ad_oe_lo = lo_on;
    assign ad_oe_hi = hi_on;
    assign ad_out   = {hi_on ? addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}},
                       lo_on ? addr[DATA_W-1:0]      : {DATA_W{1'b0}}};

    // the low lane is never driven while the memory returns data
    assert_lane_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe_lo && ad_oe_hi));
    // latch strobe and read strobe are never active together
    assert_ale_vs_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale != pol_low) |-> rd_n);
endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
    import mux_rd_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int DCYC_W      = 5,
    parameter int CLK_DIV     = 2,
    parameter int LATCH_TICKS = 2,
    parameter int FLASH_TICKS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DCYC_W-1:0] req_dcyc,
    input  logic              req_hold,
    input  logic              req_flash,
    input  logic              req_ale_low,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe_hi,
    output logic              ad_oe_lo
);
    logic              tick, accept, pol_low;
    phase_e            phase;
    logic [DCYC_W:0]   cnt, flash_len;
    logic [ADDR_W-1:0] addr;

    mux_rd_seq_tick #(.DIV(CLK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
    );

    mux_rd_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DCYC_W(DCYC_W),
        .LATCH_TICKS(LATCH_TICKS), .FLASH_TICKS(FLASH_TICKS)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_addr(req_addr), .req_dcyc(req_dcyc), .req_hold(req_hold),
        .req_flash(req_flash), .req_ale_low(req_ale_low), .ad_in(ad_in),
        .accept(accept), .phase(phase), .cnt(cnt), .flash_len(flash_len),
        .addr(addr), .pol_low(pol_low), .done(done), .rd_data(rd_data)
    );

    mux_rd_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DCYC_W(DCYC_W)) pins_i (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt), .flash_len(flash_len),
        .addr(addr), .pol_low(pol_low), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo)
    );

    assign busy = (phase != PH_IDLE);

    // busy never drops while the read strobe is low
    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> busy);
endmodule

// File: tb/mux_rd_seq_tb_top.sv
module mux_rd_seq_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, req_valid, req_hold, req_flash, req_ale_low;
    logic [15:0] req_addr;
    logic [4:0]  req_dcyc;
    logic [7:0]  ad_in;
    logic        busy, done, ale, rd_n, wr_n, ad_oe_hi, ad_oe_lo;
    logic [7:0]  rd_data;
    logic [15:0] ad_out;

    mux_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_dcyc(req_dcyc), .req_hold(req_hold), .req_flash(req_flash),
        .req_ale_low(req_ale_low), .ad_in(ad_in), .busy(busy), .done(done),
        .rd_data(rd_data), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // fields: addr[32:17] dcyc[16:12] hold[11] flash[10] pol[9] data[8:1] poke[0]
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {16'h1234, 5'd3,  1'b0, 1'b0, 1'b0, 8'h5A, 1'b0},
        {16'hABCD, 5'd0,  1'b0, 1'b0, 1'b0, 8'hC3, 1'b0},
        {16'h00FF, 5'd1,  1'b1, 1'b0, 1'b0, 8'h81, 1'b1},
        {16'h8001, 5'd2,  1'b0, 1'b1, 1'b1, 8'h7E, 1'b0},
        {16'hFFFF, 5'd31, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0},
        {16'h5555, 5'd5,  1'b1, 1'b0, 1'b0, 8'hAA, 1'b0}
    };

    task automatic run_read(input logic [32:0] v);
        logic [15:0] a;
        logic [7:0]  dat;
        int d, r, last;
        int bad [7];
        int got [7];
        int expv [7];
        bit e_ale, e_rd, e_lo, e_hi, e_done, e_busy;
        a   = v[32:17];
        dat = v[8:1];
        d   = (v[16:12] == 0) ? 1 : int'(v[16:12]);
        r   = (v[11] ? 1 : 0) + (v[10] ? 7 : 0);
        last = 9 + 2*d + 2*r;
        for (int g = 0; g < 7; g++) begin bad[g] = 0; got[g] = 0; expv[g] = 0; end
        req_addr = a; req_dcyc = v[16:12]; req_hold = v[11]; req_flash = v[10];
        req_ale_low = v[9]; req_valid = 1'b1; ad_in = ~dat;
        @(posedge clk);
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            req_valid = (v[0] && i == 3);
            if (v[0] && i == 3) req_addr = ~a;
            e_ale  = (i <= 4);
            e_lo   = (i <= 6);
            e_rd   = !(i >= 9 && i <= 8 + 2*d);
            e_hi   = (i <= 8 + 2*d + (v[11] ? 2 : 0));
            e_done = (i == 9 + 2*d);
            e_busy = (i < last);
            ad_in  = (!e_rd) ? dat : ~dat;
            if (ale !== (e_ale ^ v[9]) && bad[0]++ == 0) begin got[0] = ale; expv[0] = e_ale ^ v[9]; end
            if ((ad_oe_lo !== e_lo || (e_lo && ad_out[7:0] !== a[7:0])) && bad[1]++ == 0)
                begin got[1] = {ad_oe_lo, ad_out[7:0]}; expv[1] = {e_lo, a[7:0]}; end
            if (rd_n !== e_rd && bad[2]++ == 0) begin got[2] = i; expv[2] = e_rd; end
            if ((done !== e_done || (e_done && rd_data !== dat)) && bad[3]++ == 0)
                begin got[3] = {done, rd_data}; expv[3] = {e_done, dat}; end
            if ((ad_oe_hi !== e_hi || (e_hi && ad_out[15:8] !== a[15:8])) && bad[4]++ == 0)
                begin got[4] = {ad_oe_hi, ad_out[15:8]}; expv[4] = {e_hi, a[15:8]}; end
            if (busy !== e_busy && bad[5]++ == 0) begin got[5] = i; expv[5] = e_busy; end
            if (wr_n !== 1'b1 && bad[6]++ == 0) begin got[6] = wr_n; expv[6] = 1; end
        end
        check(bad[0] == 0, "R2 R3 latch strobe", got[0], expv[0]);
        check(bad[1] == 0, "R2 R4 low lane drive", got[1], expv[1]);
        check(bad[2] == 0, "R4 R5 read strobe (at cycle)", got[2], expv[2]);
        check(bad[3] == 0, "R6 capture", got[3], expv[3]);
        check(bad[4] == 0, "R7 upper lane drive", got[4], expv[4]);
        check(bad[5] == 0, "R8 busy window (at cycle)", got[5], expv[5]);
        check(bad[6] == 0, "R9 write strobe", got[6], expv[6]);
        check(rd_data === dat, "R6 data held", rd_data, dat);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_dcyc = '0;
        req_hold = 1'b0; req_flash = 1'b0; req_ale_low = 1'b0; ad_in = '0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        check(rd_n === 1'b1 && wr_n === 1'b1, "R1 strobes in reset", {rd_n, wr_n}, 3);
        check(ad_oe_hi === 1'b0 && ad_oe_lo === 1'b0 && ale === 1'b0,
              "R1 lanes and latch in reset", {ad_oe_hi, ad_oe_lo, ale}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && ale === 1'b0, "R1 idle after reset", {busy, ale}, 0);

        for (int k = 0; k < NV; k++) run_read(VEC[k]);

        // the last vector used active-high; run an active-low read and look at idle
        run_read({16'h0F0F, 5'd1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0});
        repeat (5) @(negedge clk);
        check(ale === 1'b1, "R3 idle level keeps active-low polarity", ale, 1);
        check(busy === 1'b0 && rd_n === 1'b1, "R8 idle after recovery", {busy, rd_n}, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule